// File: doc/BRIEF.md
# Wavefront Local-Alignment Direction Array

This block fills the two matrices of a local sequence alignment between a fixed query of `N_PE` characters and a database sequence of `M` characters. It does this one anti-diagonal per clock. There is one processing element per query character. Database characters enter element 0 one per cycle and move one element to the right on every clock. On each step, element `i` therefore handles the cell formed by query character `i` and the database character it currently holds.

Each element keeps only its own latest score, which acts as its north input, and the score its left neighbour produced one step earlier, which acts as its north-west input. The left neighbour's current score is its west input. Older scores are dropped, and no score ever leaves the array.

Each cycle the array emits one 2-bit direction code per element on a parallel bus. It always computes all `N_PE` elements. Positions before a character has reached an element, and after the last character has passed it, come out as the code for no direction. A run starts with a start pulse, which captures the query and the length. It then lasts `N_PE + M - 1` valid output cycles, followed by a one-cycle done pulse.

A controller steps through four named states. IDLE waits for a start. IDLE goes to FILL on a start with a non-zero length. FILL takes one database character per cycle for `M` cycles. FILL goes to DRAIN when `N_PE > 1`, and otherwise goes straight to TAIL. DRAIN lets the last character cross the remaining `N_PE - 1` elements. DRAIN goes to TAIL after those cycles. TAIL waits for the last codes to leave the output register. TAIL goes to IDLE in the cycle before the done pulse.

Top module: `align_wavefront_array`

## Requirements
- R1: Right after reset, `trace_valid_o` and `trace_done_o` are low and `trace_code_o` is all zero.
- R2: A start is accepted only in IDLE with `db_len_i` non-zero. Accepting it captures `query_i` and `db_len_i` and clears all stored scores. Database character `j` (0-based) is sampled on the `(j+1)`-th rising edge after the start edge. Characters presented after the last one are padding and do not change any code.
- R3: `trace_valid_o` goes high in the cycle after the second edge following the start edge. It then stays high for exactly `N_PE + M - 1` consecutive cycles. In valid cycle `s` (0-based), element `i` reports the cell for database character `s - i`.
- R4: `trace_done_o` is a single-cycle pulse. It comes in the cycle right after the last valid cycle and never coincides with `trace_valid_o`.
- R5: The cell score is max(0, NW + (chars equal ? MATCH : MISMATCH), N − GAP, W − GAP), saturating at the largest positive signed `SCORE_W`-bit value. The code of element `i` sits at bits `[2i+1:2i]`, with 01 = diagonal, 10 = up and 11 = left.
- R6: Ties are resolved with diagonal first, then up, then left. When the winning value is zero or below, the code is 00 and the score is 0.
- R7: Scores in row 0 and column 0 count as zero, so element 0 has zero west and north-west inputs and never reports 11.
- R8: An element holding no database character (ramp-up or ramp-down corner) reports 00. It keeps its score so that it acts as a zero north boundary.
- R9: Whenever `trace_valid_o` is low, `trace_code_o` is all zero.
- R10: A start raised while a run is in progress, or with `db_len_i` equal to zero, has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, one cycle |
| query_i | input | N_PE*CHAR_W | Query characters, element i at bits [i*CHAR_W +: CHAR_W] |
| db_len_i | input | LEN_W | Number of database characters M |
| db_char_i | input | CHAR_W | Database character stream, one per cycle |
| trace_valid_o | output | 1 | Direction codes on the bus are an anti-diagonal |
| trace_done_o | output | 1 | One-cycle pulse after the last anti-diagonal |
| trace_code_o | output | 2*N_PE | Direction codes, element i at bits [2i+1:2i] |

## Verification
The assertions assume that `rst_n` is applied before the first start. They also assume that the database stream is presented on exactly the edges R2 names. Any value outside those edges is padding that the array must ignore. The bench honours this by driving every input on the falling edge. It supplies arbitrary padding after the last character, and it offers a second start only while a run is in progress or with a zero length. The reference model recomputes each whole score matrix with integers and maps each cell onto its anti-diagonal cycle. It covers diagonal runs, all-tie matrices, all-mismatch matrices, a single-character database and a long pseudo-random database.

// File: rtl/align_pkg.sv
package align_pkg;

    typedef enum logic [1:0] {
        DIR_NONE = 2'b00,
        DIR_DIAG = 2'b01,
        DIR_UP   = 2'b10,
        DIR_LEFT = 2'b11
    } dir_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_DRAIN,
        ST_TAIL
    } ctrl_st_e;

endpackage

// File: rtl/align_cell.sv
module align_cell
    import align_pkg::*;
#(
    parameter int CHAR_W   = 2,
    parameter int SCORE_W  = 8,
    parameter int MATCH    = 2,
    parameter int MISMATCH = -1,
    parameter int GAP      = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               live_i,
    input  logic [CHAR_W-1:0]  q_char_i,
    input  logic [CHAR_W-1:0]  d_char_i,
    input  logic [SCORE_W-1:0] west_i,
    output logic [SCORE_W-1:0] score_o,
    output dir_e               dir_o
);

    localparam int EW = SCORE_W + 2;
    localparam logic signed [EW-1:0] ADD_MATCH = EW'(MATCH);
    localparam logic signed [EW-1:0] ADD_MISS  = EW'(MISMATCH);
    localparam logic signed [EW-1:0] GAP_S     = EW'(GAP);
    localparam logic signed [EW-1:0] ZERO_S    = '0;
    localparam logic signed [EW-1:0] SMAX_S    = EW'((2 ** (SCORE_W - 1)) - 1);

    logic [SCORE_W-1:0] score_q;
    logic [SCORE_W-1:0] nw_q;
    logic [SCORE_W-1:0] score_next;
    dir_e               dir_c;

    logic signed [EW-1:0] nw_s, n_s, w_s;
    logic signed [EW-1:0] diag_s, up_s, left_s, top_s;

    assign nw_s = signed'({2'b00, nw_q});
    assign n_s  = signed'({2'b00, score_q});
    assign w_s  = signed'({2'b00, west_i});

    always_comb begin
        diag_s = nw_s + ((q_char_i == d_char_i) ? ADD_MATCH : ADD_MISS);
        up_s   = n_s - GAP_S;
        left_s = w_s - GAP_S;
        if (diag_s >= up_s && diag_s >= left_s) begin
            top_s = diag_s;
            dir_c = DIR_DIAG;
        end else if (up_s >= left_s) begin
            top_s = up_s;
            dir_c = DIR_UP;
        end else begin
            top_s = left_s;
            dir_c = DIR_LEFT;
        end
        if (top_s <= ZERO_S) begin
            dir_c      = DIR_NONE;
            score_next = '0;
        end else if (top_s > SMAX_S) begin
            score_next = SMAX_S[SCORE_W-1:0];
        end else begin
            score_next = top_s[SCORE_W-1:0];
        end
    end

    // north-west is the west input seen one step earlier
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            score_q <= '0;
            nw_q    <= '0;
        end else if (clear_i) begin
            score_q <= '0;
            nw_q    <= '0;
        end else begin
            nw_q <= west_i;
            if (live_i) begin
                score_q <= score_next;
            end
        end
    end

    assign score_o = score_q;
    assign dir_o   = live_i ? dir_c : DIR_NONE;

endmodule

// File: rtl/align_ctrl.sv
module align_ctrl
    import align_pkg::*;
#(
    parameter int N_PE  = 4,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] db_len_i,
    output logic             accept_o,
    output logic             feed_o,
    output logic             valid_o,
    output logic             done_o
);

    localparam int PE_CW = $clog2(N_PE + 1);
    localparam int CNT_W = ((LEN_W > PE_CW) ? LEN_W : PE_CW) + 1;
    localparam logic [CNT_W-1:0] DRAIN_LAST = CNT_W'((N_PE > 1) ? (N_PE - 2) : 0);

    ctrl_st_e         state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_q;
    logic             act_q;

    assign accept_o = (state_q == ST_IDLE) && start_i && (db_len_i != '0);
    assign feed_o   = (state_q == ST_FILL);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept_o) state_d = ST_FILL;
            ST_FILL:  if (cnt_q == CNT_W'(len_q) - 1'b1)
                          state_d = (N_PE > 1) ? ST_DRAIN : ST_TAIL;
            ST_DRAIN: if (cnt_q == DRAIN_LAST) state_d = ST_TAIL;
            ST_TAIL:  if (valid_o && !act_q) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register with its step counter and captured length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            len_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
            if (accept_o) len_q <= db_len_i;
        end
    end

    // registered outputs: compute step, output valid, done pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            valid_o <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            act_q   <= (state_q == ST_FILL) || (state_q == ST_DRAIN);
            valid_o <= act_q;
            done_o  <= valid_o && !act_q;
        end
    end

endmodule

// File: rtl/align_wavefront_array.sv
module align_wavefront_array
    import align_pkg::*;
#(
    parameter int N_PE     = 4,
    parameter int CHAR_W   = 2,
    parameter int SCORE_W  = 8,
    parameter int LEN_W    = 8,
    parameter int MATCH    = 2,
    parameter int MISMATCH = -1,
    parameter int GAP      = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [N_PE*CHAR_W-1:0]   query_i,
    input  logic [LEN_W-1:0]         db_len_i,
    input  logic [CHAR_W-1:0]        db_char_i,
    output logic                     trace_valid_o,
    output logic                     trace_done_o,
    output logic [2*N_PE-1:0]        trace_code_o
);

    logic                    accept;
    logic                    feed;
    logic [N_PE*CHAR_W-1:0]  query_q;
    logic [CHAR_W-1:0]       chr_q   [N_PE];
    logic                    live_q  [N_PE];
    logic [SCORE_W-1:0]      score_w [N_PE];
    logic [2*N_PE-1:0]       dir_bus;

    align_ctrl #(.N_PE(N_PE), .LEN_W(LEN_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .db_len_i (db_len_i),
        .accept_o (accept),
        .feed_o   (feed),
        .valid_o  (trace_valid_o),
        .done_o   (trace_done_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      query_q <= '0;
        else if (accept) query_q <= query_i;
    end

    for (genvar g = 0; g < N_PE; g++) begin : g_pe
        logic [CHAR_W-1:0]  chr_src;
        logic               live_src;
        logic [SCORE_W-1:0] west;
        dir_e               dir;

        if (g == 0) begin : g_head
            assign chr_src  = db_char_i;
            assign live_src = feed;
            assign west     = '0;
        end else begin : g_body
            assign chr_src  = chr_q[g-1];
            assign live_src = live_q[g-1];
            assign west     = score_w[g-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chr_q[g]  <= '0;
                live_q[g] <= 1'b0;
            end else if (accept) begin
                chr_q[g]  <= '0;
                live_q[g] <= 1'b0;
            end else begin
                chr_q[g]  <= chr_src;
                live_q[g] <= live_src;
            end
        end

        align_cell #(
            .CHAR_W(CHAR_W), .SCORE_W(SCORE_W),
            .MATCH(MATCH), .MISMATCH(MISMATCH), .GAP(GAP)
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear_i  (accept),
            .live_i   (live_q[g]),
            .q_char_i (query_q[g*CHAR_W +: CHAR_W]),
            .d_char_i (chr_q[g]),
            .west_i   (west),
            .score_o  (score_w[g]),
            .dir_o    (dir)
        );

        assign dir_bus[2*g +: 2] = dir;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trace_code_o <= '0;
        else        trace_code_o <= dir_bus;
    end

endmodule

// File: rtl/align_wavefront_checker.sv
module align_wavefront_checker #(
    parameter int N_PE = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid,
    input logic              done,
    input logic [2*N_PE-1:0] codes
);

    a_r4_done_alone: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && valid));

    a_r4_done_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(valid));

    a_r4_valid_end_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid) |-> done);

    a_r9_quiet_codes: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (codes == '0));

    a_r7_head_no_left: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (codes[1:0] != 2'b11));

    a_r8_ramp_corner: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> ((codes >> 2) == '0));

endmodule

bind align_wavefront_array align_wavefront_checker #(.N_PE(N_PE)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (trace_valid_o),
    .done  (trace_done_o),
    .codes (trace_code_o)
);

// File: tb/sim_align_wavefront_array.sv
module sim_align_wavefront_array;

    localparam int CLK_PERIOD = 10;
    localparam int N   = 4;
    localparam int CW  = 2;
    localparam int LW  = 8;
    localparam int MAXM = 40;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [N*CW-1:0] query_i = '0;
    logic [LW-1:0]   db_len_i = '0;
    logic [CW-1:0]   db_char_i = '0;
    logic            trace_valid_o;
    logic            trace_done_o;
    logic [2*N-1:0]  trace_code_o;

    int n_chk = 0;
    int n_fail = 0;
    int qv [N];
    int dbv [MAXM];
    int hm [MAXM+1][N+1];
    int refc [MAXM][N];

    always #(CLK_PERIOD/2) clk = ~clk;

    align_wavefront_array #(.N_PE(N), .CHAR_W(CW), .LEN_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .query_i(query_i),
        .db_len_i(db_len_i), .db_char_i(db_char_i),
        .trace_valid_o(trace_valid_o), .trace_done_o(trace_done_o),
        .trace_code_o(trace_code_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // R5 R6 R7: integer reference of the full score matrix
    task automatic build_ref(input int m);
        for (int j = 0; j <= m; j++) for (int i = 0; i <= N; i++) hm[j][i] = 0;
        for (int j = 1; j <= m; j++) begin
            for (int i = 1; i <= N; i++) begin
                int d, u, l, best, code;
                d = hm[j-1][i-1] + ((qv[i-1] == dbv[j-1]) ? 2 : -1);
                u = hm[j-1][i] - 1;
                l = hm[j][i-1] - 1;
                if (d >= u && d >= l) begin best = d; code = 1; end
                else if (u >= l)      begin best = u; code = 2; end
                else                  begin best = l; code = 3; end
                if (best <= 0) begin best = 0; code = 0; end
                if (best > 127) best = 127;
                hm[j][i] = best;
                refc[j-1][i-1] = code;
            end
        end
    endtask

    // R2 R3 R4 R8 R9 R10: one run, compared on every cycle
    task automatic run_case(input int m, input bit poke);
        build_ref(m);
        @(negedge clk);
        start_i  = 1'b1;
        db_len_i = LW'(m);
        for (int i = 0; i < N; i++) query_i[i*CW +: CW] = CW'(qv[i]);
        for (int k = 0; k <= N + m + 2; k++) begin
            @(negedge clk);
            begin
                bit ev, ed;
                ev = (k >= 2) && (k <= N + m);
                ed = (k == N + m + 1);
                check(trace_valid_o == ev, "R3 valid", trace_valid_o, ev);
                check(trace_done_o == ed, "R4 done", trace_done_o, ed);
                for (int i = 0; i < N; i++) begin
                    int j, e;
                    j = k - 2 - i;
                    e = (ev && j >= 0 && j < m) ? refc[j][i] : 0;
                    check(trace_code_o[2*i +: 2] == 2'(e), "R5 R6 R8 R9 code",
                          trace_code_o[2*i +: 2], e);
                end
            end
            start_i = (poke && k == 2);
            if (poke && k == 2) begin
                query_i  = '1;
                db_len_i = 8'd9;
            end
            db_char_i = (k < m) ? CW'(dbv[k]) : CW'(k * 3 + 1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(trace_valid_o == 1'b0, "R1 valid", trace_valid_o, 0);
        check(trace_done_o == 1'b0, "R1 done", trace_done_o, 0);
        check(trace_code_o == '0, "R1 codes", trace_code_o, 0);

        // diagonal matches
        for (int i = 0; i < N; i++) begin qv[i] = i; dbv[i] = i; end
        run_case(4, 1'b0);
        // all equal characters: ties everywhere
        for (int i = 0; i < N; i++) qv[i] = 1;
        for (int j = 0; j < 6; j++) dbv[j] = 1;
        run_case(6, 1'b0);
        // all mismatch: no direction anywhere
        for (int i = 0; i < N; i++) qv[i] = 0;
        for (int j = 0; j < 3; j++) dbv[j] = 3;
        run_case(3, 1'b0);
        // single database character
        for (int i = 0; i < N; i++) qv[i] = (i * 2) % 4;
        dbv[0] = 2;
        run_case(1, 1'b0);
        // long pseudo-random database, with a start poke mid-run (R10)
        qv[0] = 2; qv[1] = 0; qv[2] = 3; qv[3] = 2;
        for (int j = 0; j < 20; j++) dbv[j] = (j * 7 + j / 3) % 4;
        run_case(20, 1'b1);
        // R10: zero-length start is ignored
        @(negedge clk);
        start_i  = 1'b1;
        db_len_i = '0;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(trace_valid_o == 1'b0, "R10 zero length", trace_valid_o, 0);
            check(trace_code_o == '0, "R10 zero length codes", trace_code_o, 0);
        end
        // back-to-back run after the ignored start
        qv[0] = 1; qv[1] = 2; qv[2] = 1; qv[3] = 2;
        for (int j = 0; j < 5; j++) dbv[j] = (j % 2) + 1;
        run_case(5, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule